// File: doc/BRIEF.md
# Pipelined Word Memory Subordinate for AHB-Lite

This block is an AHB-Lite subordinate that fronts a small array of word registers. It uses the bus's two-stage pipeline. On the clock edge that ends an address phase it captures the word index, the direction and a wait request into a data-phase stage. In the next cycle it moves the data, while the manager already drives the next address. With no waits, back-to-back transfers complete at one per clock once the first has filled the pipe.

A side input, `stall_req`, is sampled together with an accepted address phase. It makes the following data phase last two cycles: HREADYOUT is low for exactly one cycle and then high. While HREADY is low, the whole pipeline holds. The pending address phase is not taken, the data-phase stage keeps its transfer, and a write waits for its completing cycle.

Only whole, aligned words are supported, and every response is OKAY. Transfers of any other size or alignment are treated like IDLE.

Top module: `ahbl_pipe_mem`

## Requirements
- R1: While reset is asserted and in the first cycle after it, HREADYOUT is 1, HRESP is 0 and HRDATA is 0. The whole array holds zero after reset.
- R2: An address phase is accepted only when HSEL is 1 and HREADY is 1 and HTRANS is NONSEQ (2'b10) or SEQ (2'b11). An unselected transfer leaves the array unchanged.
- R3: For an accepted write, the data on HWDATA in the cycle after the address phase is stored into word HADDR[ADDR_W-1:2]. The store happens on the edge that ends the data-phase cycle in which HREADYOUT is 1.
- R4: During the data phase of an accepted read, HRDATA shows the addressed word. With `stall_req` low, consecutive transfers complete one per clock and HREADYOUT stays 1.
- R5: When `stall_req` is 1 during an accepted address phase, HREADYOUT is 0 for exactly the first cycle of that transfer's data phase and 1 in the next cycle.
- R6: While HREADY is 0, the address phase on the bus is not consumed and the data-phase transfer is held. After the stall, both complete in order, with no lost or repeated access.
- R7: IDLE (2'b00) and BUSY (2'b01) transfers cause no data-phase action. In the following cycle HRDATA is 0 and the array is unchanged.
- R8: A read of a word in the cycle right after the completing write to the same word returns the newly written data.
- R9: HRESP is 0 (OKAY) in every cycle.
- R10: A transfer whose HSIZE is not 3'b010 (word), or whose HADDR[1:0] is not 2'b00, is treated like IDLE. It writes nothing and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | ADDR_W | Byte address; ADDR_W = log2(DEPTH)+2 |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size; only word is serviced |
| hwdata | input | DATA_W | Write data, valid in the data phase |
| hready | input | 1 | Bus-wide ready, the pipeline advance enable |
| stall_req | input | 1 | Request one wait state for the current address phase |
| hrdata | output | DATA_W | Read data |
| hreadyout | output | 1 | This subordinate's ready |
| hresp | output | 1 | Response, always OKAY |

## Verification
The assertions assume that HREADY is this block's own HREADYOUT returned through the bus, as in a system with a single subordinate. Under that assumption a wait state lasts exactly one cycle, and a held address phase is not taken. The bench ties the two together.

The bench also obeys the manager's hold rule. It keeps every address-phase signal, and HWDATA, unchanged through each low-HREADY cycle. It never presents a new transfer before the previous one has been taken.

// File: rtl/ahbl_pipe_pkg.sv
package ahbl_pipe_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] SZ_WORD = 3'b010;

  // NONSEQ and SEQ both carry bit 1 set; IDLE and BUSY do not.
  function automatic logic trans_moves(input logic [1:0] tr);
    return tr[1];
  endfunction

  // Only aligned whole-word transfers are serviced.
  function automatic logic word_shape_ok(input logic [2:0] sz, input logic [1:0] lo);
    return (sz == SZ_WORD) && (lo == 2'b00);
  endfunction

  function automatic logic take_addr(input logic sel, input logic rdy,
                                     input logic [1:0] tr, input logic [2:0] sz,
                                     input logic [1:0] lo);
    return sel && rdy && trans_moves(tr) && word_shape_ok(sz, lo);
  endfunction

endpackage

// File: rtl/ahbl_pipe_addr_stage.sv
module ahbl_pipe_addr_stage
  import ahbl_pipe_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        trans,
  input  logic              write,
  input  logic [2:0]        size,
  input  logic              ready_in,
  input  logic              wait_in,
  output logic              accept,
  output logic              dp_valid,
  output logic              dp_write,
  output logic [IDX_W-1:0]  dp_idx,
  output logic              dp_wait
);

  assign accept = take_addr(sel, ready_in, trans, size, addr[1:0]);

  // Data-phase stage: advances only when the bus is ready.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_idx   <= '0;
    end else if (ready_in) begin
      dp_valid <= accept;
      if (accept) begin
        dp_write <= write;
        dp_idx   <= addr[ADDR_W-1:2];
      end
    end
  end

  // The wait flag lives for one cycle: a low ready clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dp_wait <= 1'b0;
    else        dp_wait <= ready_in ? (accept && wait_in) : 1'b0;
  end

  p_accept_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dp_valid);

  p_idle_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_in && !accept) |=> !dp_valid);

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_in |=> ($stable(dp_valid) && $stable(dp_write) && $stable(dp_idx)));

endmodule

// File: rtl/ahbl_pipe_resp.sv
module ahbl_pipe_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_valid,
  input  logic dp_write,
  input  logic dp_wait,
  output logic ready_out,
  output logic resp,
  output logic wr_en,
  output logic rd_en
);

  assign ready_out = !(dp_valid && dp_wait);
  assign resp      = 1'b0;
  assign wr_en     = dp_valid && dp_write && ready_out;
  assign rd_en     = dp_valid && !dp_write;

  p_single_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_out |=> ready_out);

endmodule

// File: rtl/ahbl_pipe_store.sv
module ahbl_pipe_store #(
  parameter int DEPTH = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               words[g] <= '0;
      else if (wr_en && (idx == IDX_W'(g)))     words[g] <= wdata;
    end
  end

  // Direct read of the register array gives read-after-write for free.
  assign rdata = rd_en ? words[idx] : '0;

endmodule

// File: rtl/ahbl_pipe_mem.sv
module ahbl_pipe_mem #(
  parameter int DEPTH = 64,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  input  logic              stall_req,
  output logic [DATA_W-1:0] hrdata,
  output logic              hreadyout,
  output logic              hresp
);

  logic             accept;
  logic             dp_valid;
  logic             dp_write;
  logic [IDX_W-1:0] dp_idx;
  logic             dp_wait;
  logic             wr_en;
  logic             rd_en;

  ahbl_pipe_addr_stage #(.DEPTH(DEPTH)) u_addr (
    .clk(hclk), .rst_n(hresetn), .sel(hsel), .addr(haddr), .trans(htrans),
    .write(hwrite), .size(hsize), .ready_in(hready), .wait_in(stall_req),
    .accept(accept), .dp_valid(dp_valid), .dp_write(dp_write),
    .dp_idx(dp_idx), .dp_wait(dp_wait)
  );

  ahbl_pipe_resp u_resp (
    .clk(hclk), .rst_n(hresetn), .dp_valid(dp_valid), .dp_write(dp_write),
    .dp_wait(dp_wait), .ready_out(hreadyout), .resp(hresp),
    .wr_en(wr_en), .rd_en(rd_en)
  );

  ahbl_pipe_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(hclk), .rst_n(hresetn), .wr_en(wr_en), .rd_en(rd_en),
    .idx(dp_idx), .wdata(hwdata), .rdata(hrdata)
  );

  p_wait_inserted_r5: assert property (@(posedge hclk) disable iff (!hresetn)
    (accept && stall_req) |=> !hreadyout);

  p_no_wait_r4: assert property (@(posedge hclk) disable iff (!hresetn)
    (hready && !(accept && stall_req)) |=> hreadyout);

  p_raw_fresh_r8: assert property (@(posedge hclk) disable iff (!hresetn)
    wr_en |=> (!(rd_en && (dp_idx == $past(dp_idx))) || (hrdata == $past(hwdata))));

endmodule

// File: tb/ahbl_pipe_mem_tb.sv
`timescale 1ns/1ps
module ahbl_pipe_mem_tb;
  localparam int DEPTH = 64;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          hclk = 1'b0;
  logic          hresetn = 1'b0;
  logic          hsel = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [1:0]    htrans = 2'b00;
  logic          hwrite = 1'b0;
  logic [2:0]    hsize = 3'b010;
  logic [DW-1:0] hwdata = '0;
  logic          hready;
  logic          stall_req = 1'b0;
  logic [DW-1:0] hrdata;
  logic          hreadyout;
  logic          hresp;

  always #2.5 hclk = ~hclk;
  assign hready = hreadyout;

  ahbl_pipe_mem #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .stall_req(stall_req), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp)
  );

  typedef struct {
    bit          sel;
    bit [1:0]    tr;
    bit [AW-1:0] addr;
    bit          wr;
    bit [2:0]    sz;
    bit          wq;
    bit [DW-1:0] wd;
    string       tag;
  } item_t;

  item_t         q[$];
  logic [DW-1:0] mem_m [DEPTH];
  int            n_cmp = 0;
  int            n_bad = 0;
  bit            done = 0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(bit sel, bit [1:0] tr, int addr, bit wr, bit [2:0] sz,
                      bit wq, logic [DW-1:0] wd, string tag);
    item_t it;
    it.sel = sel; it.tr = tr; it.addr = addr[AW-1:0]; it.wr = wr;
    it.sz = sz; it.wq = wq; it.wd = wd; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr_w(int addr, logic [DW-1:0] d, bit wq, string tag);
    push(1, 2'b10, addr, 1, 3'b010, wq, d, tag);
  endtask

  task automatic rd_w(int addr, bit wq, string tag);
    push(1, 2'b10, addr, 0, 3'b010, wq, '0, tag);
  endtask

  initial begin
    item_t cur;
    bit m_valid, m_write, m_wait, hold, exp_rdy, acc;
    int m_idx;
    logic [DW-1:0] m_wd;
    string m_tag;
    m_valid = 0; m_write = 0; m_wait = 0; hold = 0; m_idx = 0; m_wd = '0; m_tag = "R7";
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;

    repeat (3) @(negedge hclk);
    chk("R1", {31'b0, hreadyout}, 32'd1);
    chk("R1", {31'b0, hresp}, 32'd0);
    chk("R1", hrdata, '0);
    hresetn = 1'b1;
    @(negedge hclk);
    chk("R1", {31'b0, hreadyout}, 32'd1);
    chk("R1", hrdata, '0);

    // R3 / R4: back-to-back writes then reads, NONSEQ and SEQ
    for (int i = 0; i < 4; i++) wr_w(i * 4, 32'hA500_0000 + i, 0, "R3");
    for (int i = 0; i < 4; i++) rd_w(i * 4, 0, "R3");
    for (int i = 0; i < 4; i++) push(1, 2'b11, i * 4, 0, 3'b010, 0, '0, "R4");
    // R8: read straight after write of same word
    wr_w(8'h10, 32'hDEAD_BEEF, 0, "R8");
    rd_w(8'h10, 0, "R8");
    // R5 / R6: waited write, held read, waited read
    wr_w(8'h20, 32'h1234_5678, 1, "R5");
    rd_w(8'h20, 0, "R6");
    rd_w(8'h24, 1, "R5");
    wr_w(8'h24, 32'h0BAD_F00D, 1, "R6");
    rd_w(8'h24, 1, "R6");
    // R7: IDLE and BUSY with write direction do nothing
    push(1, 2'b00, 8'h00, 1, 3'b010, 0, 32'hFFFF_FFFF, "R7");
    push(1, 2'b01, 8'h00, 1, 3'b010, 1, 32'hFFFF_FFFF, "R7");
    rd_w(8'h00, 0, "R7");
    // R2: unselected write
    push(0, 2'b10, 8'h04, 1, 3'b010, 0, 32'h5555_5555, "R2");
    rd_w(8'h04, 0, "R2");
    // R10: byte size and misaligned word
    push(1, 2'b10, 8'h08, 1, 3'b000, 0, 32'h7777_7777, "R10");
    push(1, 2'b10, 8'h09, 1, 3'b010, 0, 32'h6666_6666, "R10");
    push(1, 2'b10, 8'h09, 0, 3'b010, 0, '0, "R10");
    rd_w(8'h08, 0, "R10");
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      int kind = $urandom_range(0, 9);
      int a = $urandom_range(0, 15) * 4;
      bit wq = ($urandom_range(0, 4) == 0);
      if (kind < 4)      wr_w(a, $urandom(), wq, "R4");
      else if (kind < 8) rd_w(a, wq, "R4");
      else               push(1, kind[1:0] == 2'b00 ? 2'b00 : 2'b01, a, 1, 3'b010, wq, '0, "R7");
    end

    while (q.size() > 0 || m_valid || hold) begin
      @(negedge hclk);
      if (!hold) begin
        if (q.size() > 0) cur = q.pop_front();
        else begin
          cur.sel = 0; cur.tr = 2'b00; cur.addr = '0; cur.wr = 0;
          cur.sz = 3'b010; cur.wq = 0; cur.wd = '0; cur.tag = "R7";
        end
      end
      hsel = cur.sel; htrans = cur.tr; haddr = cur.addr; hwrite = cur.wr;
      hsize = cur.sz; stall_req = cur.wq;
      hwdata = m_write ? m_wd : '0;
      #1;
      exp_rdy = !(m_valid && m_wait);
      chk((m_valid && m_wait) ? "R5" : "R4", {31'b0, hreadyout}, {31'b0, exp_rdy});
      chk("R9", {31'b0, hresp}, 32'd0);
      chk(m_valid ? m_tag : "R7", hrdata, (m_valid && !m_write) ? mem_m[m_idx] : '0);
      // reference update for the coming edge
      if (m_valid && m_write && exp_rdy) mem_m[m_idx] = m_wd;
      if (exp_rdy) begin
        acc = cur.sel && cur.tr[1] && (cur.sz == 3'b010) && (cur.addr[1:0] == 2'b00);
        m_valid = acc;
        if (acc) begin
          m_write = cur.wr; m_idx = int'(cur.addr >> 2); m_wd = cur.wd; m_tag = cur.tag;
        end
        m_wait = acc && cur.wq;
        hold = 0;
      end else begin
        m_wait = 0;
        hold = 1;
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge hclk);
    if (!done) begin
      n_bad++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule